// File: doc/BRIEF.md
# Bus-Master Transmit FIFO with Wait-State Prediction

This block sits between a processor core and a parallel bus interface that is acting as bus master. The core pushes 24-bit words into an eight-entry transmit FIFO. A write transaction on the bus then drains the FIFO, one word per data phase. A request flag tells the core that the FIFO can take another word. That flag drives an interrupt request and a DMA request, each through its own enable.

While a transaction runs, the block looks one word ahead. A write transaction stops being safe when the transmit FIFO holds only one word. A read transaction stops being safe when the receive path reports only one free slot. In either case the block raises a wait-state flag and drops its master-ready output, which stretches the data phase. The core can then pulse a terminate control. The block completes the pending data phase, even though the flag is set, and then closes the transaction with a one-cycle done pulse.

Three kinds of reset are supported:
- an asynchronous hardware reset;
- a synchronous software reset pulse;
- a level-held personal reset state, during which the request and wait flags read 0.

Top module: `mtx_fifo_ctrl`

## Requirements
- R1: The transmit FIFO holds DEPTH (default 8) words of 24 bits and returns them in first-in first-out order. A core write while the FIFO holds DEPTH words is ignored.
- R2: `tx_req_o` is 1 exactly when the FIFO holds fewer than DEPTH words and `pers_rst_i` is 0. It returns to 1 as soon as a word leaves the FIFO toward the bus.
- R3: `tx_irq_o` equals `tx_req_o` AND `tx_irq_en_i`. `tx_dma_o` equals `tx_req_o` AND `dma_en_i`.
- R4: Reset behaviour:
  - `rst_ni` low, or a `soft_rst_i` pulse, empties the FIFO, ends any transaction and clears the terminate bit. Afterwards `tx_req_o`=1 and `ws_flag_o`=0.
  - While `pers_rst_i` is 1, the FIFO is held empty, core writes and transaction starts are ignored, and `tx_req_o` and `ws_flag_o` read 0.
- R5: Starting and running a transaction:
  - A `xfer_start_i` pulse while idle starts a transaction one cycle later. Its direction is taken from `xfer_dir_i` (1 = write to bus, 0 = read from bus).
  - A data phase completes in each cycle in which `mst_rdy_o` and `tgt_rdy_i` are both 1.
  - In a write transaction, each completed phase removes the word shown on `bus_data_o`. `mst_rdy_o` is 0 while the FIFO is empty.
- R6: In a write transaction with `ws_dis_i`=0, `ws_flag_o` is 1 while the FIFO holds exactly one word. While `ws_flag_o` is 1 and the terminate bit is 0, `mst_rdy_o` is 0.
- R7: Read transactions:
  - With `ws_dis_i`=0, `ws_flag_o` is 1 while `rx_free_i` equals 1.
  - `mst_rdy_o` is 0 while `rx_free_i` is 0.
  - Each completed read phase pulses `rx_push_o` and leaves the transmit FIFO untouched.
- R8: While `ws_dis_i` is 1, `ws_flag_o` stays 0 and no wait state is inserted.
- R9: Termination:
  - A `term_set_i` pulse during a transaction sets `term_bit_o` one cycle later. The next data phase then completes even if `ws_flag_o` is 1.
  - In the cycle after that phase, `xfer_active_o` and `term_bit_o` are 0 and `xfer_done_o` is 1 for exactly one cycle.
  - `term_set_i` while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous software reset pulse |
| pers_rst_i | input | 1 | Personal reset state, level |
| wr_valid_i | input | 1 | Core write strobe |
| wr_data_i | input | 24 | Core write data |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| dma_en_i | input | 1 | Transmit DMA enable |
| ws_dis_i | input | 1 | Wait-state generation disable |
| term_set_i | input | 1 | Core sets terminate bit (pulse) |
| xfer_start_i | input | 1 | Start a transaction (pulse) |
| xfer_dir_i | input | 1 | Direction: 1 write to bus, 0 read from bus |
| tgt_rdy_i | input | 1 | Target ready |
| rx_free_i | input | 4 | Free slots in the receive path |
| mst_rdy_o | output | 1 | Master ready |
| bus_data_o | output | 24 | FIFO head word driven toward the bus |
| rx_push_o | output | 1 | A read phase delivered a word to the receive path |
| xfer_active_o | output | 1 | Transaction in progress |
| xfer_done_o | output | 1 | One-cycle pulse after a terminated transaction |
| term_bit_o | output | 1 | Terminate bit |
| tx_req_o | output | 1 | Transmit request: FIFO can accept a write |
| tx_irq_o | output | 1 | Transmit interrupt request |
| tx_dma_o | output | 1 | Transmit DMA request |
| ws_flag_o | output | 1 | Wait-state flag |

## Verification
The hardest state to reach is a write transaction stalled on its last word. This state needs three conditions at once: the FIFO down to one entry, wait states enabled, and the target ready. Only then does the terminate bit decide whether that word ever leaves.

The bench gets there by loading three words with the target held off. It starts a write, then releases the target. The first two words drain, and the bench confirms the stall lasts several cycles. It then pulses terminate and checks that the final word leaves and that the done pulse lands in the following cycle. A second hard case is a software reset arriving in the middle of a stalled transaction. It is reached the same way, and the bench proves the flush by seeing master ready stay low in a fresh write transaction.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic      active;
    xfer_dir_e dir;
    logic      term;
    logic      done;
  } xfer_state_t;
endpackage

// File: rtl/mtx_fifo.sv
module mtx_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem[rd_ptr];
  assign cnt_o   = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/mtx_ws_pred.sv
module mtx_ws_pred
  import mtx_pkg::*;
#(
  parameter int CW  = 4,
  parameter int RFW = 4
) (
  input  logic           active_i,
  input  xfer_dir_e      dir_i,
  input  logic           ws_dis_i,
  input  logic [CW-1:0]  tx_cnt_i,
  input  logic [RFW-1:0] rx_free_i,
  output logic           ws_o,
  output logic           avail_o
);
  logic last_slot;

  // one word of margin left: next phase cannot be guaranteed
  always_comb begin
    if (dir_i == DIR_WRITE) begin
      last_slot = (tx_cnt_i == CW'(1));
      avail_o   = (tx_cnt_i != '0);
    end else begin
      last_slot = (rx_free_i == RFW'(1));
      avail_o   = (rx_free_i != '0);
    end
  end

  assign ws_o = active_i && !ws_dis_i && last_slot;
endmodule

// File: rtl/mtx_xfer_ctl.sv
module mtx_xfer_ctl
  import mtx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        start_i,
  input  xfer_dir_e   dir_i,
  input  logic        term_set_i,
  input  logic        phase_i,
  output xfer_state_t st_o
);
  xfer_state_t st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= '{active: 1'b0, dir: DIR_READ, term: 1'b0, done: 1'b0};
    end else if (clr_i) begin
      st.active <= 1'b0;
      st.term   <= 1'b0;
      st.done   <= 1'b0;
    end else begin
      st.done <= 1'b0;
      if (!st.active) begin
        if (start_i) begin
          st.active <= 1'b1;
          st.dir    <= dir_i;
        end
      end else if (phase_i && st.term) begin
        st.active <= 1'b0;
        st.term   <= 1'b0;
        st.done   <= 1'b1;
      end else if (term_set_i) begin
        st.term <= 1'b1;
      end
    end
  end

  assign st_o = st;
endmodule

// File: rtl/mtx_fifo_ctrl.sv
module mtx_fifo_ctrl
  import mtx_pkg::*;
#(
  parameter int DW       = 24,
  parameter int DEPTH    = 8,
  parameter int RX_DEPTH = 8,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int RFW     = $clog2(RX_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           soft_rst_i,
  input  logic           pers_rst_i,
  input  logic           wr_valid_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           tx_irq_en_i,
  input  logic           dma_en_i,
  input  logic           ws_dis_i,
  input  logic           term_set_i,
  input  logic           xfer_start_i,
  input  logic           xfer_dir_i,
  input  logic           tgt_rdy_i,
  input  logic [RFW-1:0] rx_free_i,
  output logic           mst_rdy_o,
  output logic [DW-1:0]  bus_data_o,
  output logic           rx_push_o,
  output logic           xfer_active_o,
  output logic           xfer_done_o,
  output logic           term_bit_o,
  output logic           tx_req_o,
  output logic           tx_irq_o,
  output logic           tx_dma_o,
  output logic           ws_flag_o
);
  logic          flush, phase, tx_pop, tx_full, tx_empty, ws_int, avail;
  logic [CW-1:0] tx_cnt;
  xfer_state_t   xs;

  assign flush = soft_rst_i || pers_rst_i;

  mtx_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (wr_valid_i),
    .data_i  (wr_data_i),
    .pop_i   (tx_pop),
    .head_o  (bus_data_o),
    .cnt_o   (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  mtx_ws_pred #(.CW(CW), .RFW(RFW)) u_ws (
    .active_i  (xs.active),
    .dir_i     (xs.dir),
    .ws_dis_i  (ws_dis_i),
    .tx_cnt_i  (tx_cnt),
    .rx_free_i (rx_free_i),
    .ws_o      (ws_int),
    .avail_o   (avail)
  );

  mtx_xfer_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (flush),
    .start_i    (xfer_start_i),
    .dir_i      (xfer_dir_e'(xfer_dir_i)),
    .term_set_i (term_set_i),
    .phase_i    (phase),
    .st_o       (xs)
  );

  // terminate overrides the stall for exactly one more phase
  assign mst_rdy_o     = xs.active && avail && !flush && (!ws_int || xs.term);
  assign phase         = mst_rdy_o && tgt_rdy_i;
  assign tx_pop        = phase && (xs.dir == DIR_WRITE);
  assign rx_push_o     = phase && (xs.dir == DIR_READ);
  assign xfer_active_o = xs.active;
  assign xfer_done_o   = xs.done;
  assign term_bit_o    = xs.term;
  assign ws_flag_o     = ws_int && !pers_rst_i;
  assign tx_req_o      = !tx_full && !pers_rst_i;
  assign tx_irq_o      = tx_req_o && tx_irq_en_i;
  assign tx_dma_o      = tx_req_o && dma_en_i;

  logic unused_empty;
  assign unused_empty = tx_empty;
endmodule

// File: rtl/mtx_fifo_ctrl_chk.sv
module mtx_fifo_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] tx_cnt,
  input logic          tx_req_o,
  input logic          tx_irq_o,
  input logic          tx_irq_en_i,
  input logic          pers_rst_i,
  input logic          ws_flag_o,
  input logic          ws_dis_i,
  input logic          term_bit_o,
  input logic          mst_rdy_o,
  input logic          xfer_done_o,
  input logic          xfer_active_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH)); // R1
  AST_FULL_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt == CW'(DEPTH)) |-> !tx_req_o); // R2
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (tx_req_o && tx_irq_en_i)); // R3
  AST_PERS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pers_rst_i |-> (!tx_req_o && !ws_flag_o)); // R4
  AST_WS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_flag_o && !term_bit_o) |-> !mst_rdy_o); // R6
  AST_WS_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ws_dis_i |-> !ws_flag_o); // R8
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> (!xfer_active_o && !term_bit_o)); // R9
  AST_DONE_AFTER_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> $past(term_bit_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |=> !xfer_done_o); // R9
endmodule

bind mtx_fifo_ctrl mtx_fifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_cnt        (tx_cnt),
  .tx_req_o      (tx_req_o),
  .tx_irq_o      (tx_irq_o),
  .tx_irq_en_i   (tx_irq_en_i),
  .pers_rst_i    (pers_rst_i),
  .ws_flag_o     (ws_flag_o),
  .ws_dis_i      (ws_dis_i),
  .term_bit_o    (term_bit_o),
  .mst_rdy_o     (mst_rdy_o),
  .xfer_done_o   (xfer_done_o),
  .xfer_active_o (xfer_active_o)
);

// File: tb/mtx_fifo_ctrl_test.sv
module mtx_fifo_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni, soft_rst_i, pers_rst_i, wr_valid_i;
  logic [23:0] wr_data_i;
  logic        tx_irq_en_i, dma_en_i, ws_dis_i, term_set_i;
  logic        xfer_start_i, xfer_dir_i, tgt_rdy_i;
  logic [3:0]  rx_free_i;
  logic        mst_rdy_o, rx_push_o, xfer_active_o, xfer_done_o, term_bit_o;
  logic [23:0] bus_data_o;
  logic        tx_req_o, tx_irq_o, tx_dma_o, ws_flag_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  mtx_fifo_ctrl uut (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk_i);
    #1;
  endtask

  task automatic push(input logic [23:0] d);
    @(negedge clk_i);
    wr_valid_i = 1'b1;
    wr_data_i  = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    #1;
  endtask

  task automatic start(input logic dir);
    @(negedge clk_i);
    xfer_start_i = 1'b1;
    xfer_dir_i   = dir;
    @(negedge clk_i);
    xfer_start_i = 1'b0;
    #1;
  endtask

  task automatic pulse_term();
    @(negedge clk_i);
    term_set_i = 1'b1;
    @(negedge clk_i);
    term_set_i = 1'b0;
    #1;
  endtask

  task automatic pulse_soft();
    @(negedge clk_i);
    soft_rst_i = 1'b1;
    @(negedge clk_i);
    soft_rst_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; soft_rst_i = 0; pers_rst_i = 0; wr_valid_i = 0; wr_data_i = '0;
    tx_irq_en_i = 0; dma_en_i = 0; ws_dis_i = 0; term_set_i = 0;
    xfer_start_i = 0; xfer_dir_i = 0; tgt_rdy_i = 0; rx_free_i = 4'd8;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    chk("R4 reset tx_req", tx_req_o, 1);
    chk("R4 reset ws_flag", ws_flag_o, 0);
    chk("R4 reset active", xfer_active_o, 0);
    chk("R5 reset mst_rdy", mst_rdy_o, 0);
    tx_irq_en_i = 1; #1;
    chk("R3 irq with enable", tx_irq_o, 1);
    chk("R3 dma without enable", tx_dma_o, 0);
    dma_en_i = 1; #1;
    chk("R3 dma with enable", tx_dma_o, 1);
  endtask

  task automatic t_full_order();
    logic [23:0] got [8];
    int n = 0;
    for (int i = 0; i < 8; i++) push(24'h100 + 24'(i));
    chk("R2 full clears tx_req", tx_req_o, 0);
    chk("R3 irq low when full", tx_irq_o, 0);
    chk("R3 dma low when full", tx_dma_o, 0);
    push(24'hBAD);
    chk("R1 write when full ignored", tx_req_o, 0);
    ws_dis_i = 1;
    start(1'b1);
    chk("R5 write xfer active", xfer_active_o, 1);
    tgt_rdy_i = 1; #1;
    for (int c = 0; c < 12; c++) begin
      if (mst_rdy_o && n < 8) begin got[n] = bus_data_o; n++; end
      chk("R8 no wait state when disabled", ws_flag_o, 0);
      settle();
      if (c == 0) chk("R2 tx_req rises after pop", tx_req_o, 1);
    end
    chk("R1 word count", 32'(n), 8);
    for (int i = 0; i < 8; i++) chk("R1 fifo order", got[i], 24'h100 + 24'(i));
    chk("R5 ready low when empty", mst_rdy_o, 0);
    tgt_rdy_i = 0;
    pulse_term();
    chk("R9 term bit set", term_bit_o, 1);
    push(24'h55);
    chk("R5 ready with data", mst_rdy_o, 1);
    tgt_rdy_i = 1;
    settle();
    tgt_rdy_i = 0;
    chk("R9 done pulse", xfer_done_o, 1);
    chk("R9 transaction ended", xfer_active_o, 0);
    chk("R9 term bit cleared", term_bit_o, 0);
    settle();
    chk("R9 done one cycle", xfer_done_o, 0);
    ws_dis_i = 0;
  endtask

  task automatic t_write_ws();
    push(24'hA1); push(24'hB2); push(24'hC3);
    start(1'b1);
    tgt_rdy_i = 1; #1;
    chk("R5 first word", bus_data_o, 24'hA1);
    chk("R5 ready", mst_rdy_o, 1);
    settle();
    chk("R5 second word", bus_data_o, 24'hB2);
    chk("R6 no ws at two words", ws_flag_o, 0);
    settle();
    chk("R6 ws at one word", ws_flag_o, 1);
    chk("R6 ready dropped", mst_rdy_o, 0);
    repeat (3) settle();
    chk("R6 stall holds", mst_rdy_o, 0);
    chk("R6 last word held", bus_data_o, 24'hC3);
    @(negedge clk_i);
    term_set_i = 1'b1;
    @(negedge clk_i);
    term_set_i = 1'b0;
    #1;
    chk("R9 term overrides stall", mst_rdy_o, 1);
    chk("R9 ws still set", ws_flag_o, 1);
    settle();
    chk("R9 done after final phase", xfer_done_o, 1);
    chk("R9 active cleared", xfer_active_o, 0);
    chk("R5 fifo drained ready", mst_rdy_o, 0);
    tgt_rdy_i = 0;
  endtask

  task automatic t_read();
    for (int i = 0; i < 8; i++) push(24'h200 + 24'(i));
    rx_free_i = 4'd4;
    start(1'b0);
    chk("R7 read ready", mst_rdy_o, 1);
    chk("R7 no ws at 4 free", ws_flag_o, 0);
    rx_free_i = 4'd1; #1;
    chk("R7 ws at one free", ws_flag_o, 1);
    chk("R7 stall at one free", mst_rdy_o, 0);
    rx_free_i = 4'd0; #1;
    chk("R7 ready low at zero free", mst_rdy_o, 0);
    chk("R7 no ws at zero free", ws_flag_o, 0);
    ws_dis_i = 1; rx_free_i = 4'd1; #1;
    chk("R8 read ws disabled", ws_flag_o, 0);
    chk("R8 read ready when disabled", mst_rdy_o, 1);
    ws_dis_i = 0; rx_free_i = 4'd3; tgt_rdy_i = 1; #1;
    chk("R7 rx push on phase", rx_push_o, 1);
    settle();
    settle();
    tgt_rdy_i = 0; #1;
    chk("R7 read leaves tx fifo", tx_req_o, 0);
    rx_free_i = 4'd1;
    pulse_term();
    chk("R9 read term override", mst_rdy_o, 1);
    tgt_rdy_i = 1;
    settle();
    tgt_rdy_i = 0;
    chk("R9 read done", xfer_done_o, 1);
    rx_free_i = 4'd8;
  endtask

  task automatic t_soft();
    pulse_term();
    chk("R9 term ignored idle", term_bit_o, 0);
    start(1'b1);
    chk("R9 term still clear", term_bit_o, 0);
    pulse_soft();
    chk("R4 soft reset tx_req", tx_req_o, 1);
    chk("R4 soft reset ends xfer", xfer_active_o, 0);
    chk("R4 soft reset ws", ws_flag_o, 0);
    start(1'b1);
    tgt_rdy_i = 1; #1;
    chk("R4 soft reset flushed", mst_rdy_o, 0);
    tgt_rdy_i = 0;
    pulse_soft();
    push(24'h11);
    start(1'b1);
    chk("R6 one word ws", ws_flag_o, 1);
    pulse_soft();
    chk("R4 soft clears ws", ws_flag_o, 0);
  endtask

  task automatic t_pers();
    push(24'h31); push(24'h32);
    @(negedge clk_i);
    pers_rst_i = 1; #1;
    chk("R4 pers tx_req", tx_req_o, 0);
    chk("R4 pers irq", tx_irq_o, 0);
    push(24'h33);
    start(1'b1);
    chk("R4 pers start ignored", xfer_active_o, 0);
    @(negedge clk_i);
    pers_rst_i = 0; #1;
    chk("R4 pers release tx_req", tx_req_o, 1);
    start(1'b1);
    tgt_rdy_i = 1; #1;
    chk("R4 pers flushed fifo", mst_rdy_o, 0);
    tgt_rdy_i = 0;
    pulse_soft();
  endtask

  initial begin
    t_reset();
    t_full_order();
    t_write_ws();
    t_read();
    t_soft();
    t_pers();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule